// File: doc/BRIEF.md
# I/O Bus Port Decoder with Input Wait

This block sits on a microprocessor system bus in front of a board that holds four peripheral ports. Each port has two sections, and each section has a control channel and a data channel. The board takes up a window of 16 consecutive I/O addresses. The window base is set by a 4-bit setting compared against the upper address nibble.

A bus cycle reaches the board only when two things hold at once: the address falls in the board window, and the input or output status strobe is active. Such an access drives the following outputs:

- a one-hot chip select for one of the four ports;
- a 2-bit register select;
- a read/write line;
- an enable strobe built from the data-in and write strobes;
- direction enables for the data buffers.

Input accesses hold the ready line low for a fixed number of clocks, which gives the ports address setup time. Output accesses never wait. Power-on clear drives the port reset line, clears the wait timer and keeps ready high.

Top module: `io_port_decoder`

## Requirements
- R1: An access is qualified only when addr[7:4] equals base_sel and sts_in or sts_out is high. Without a qualified access, port_cs is 0, reg_sel is 00, bus_en, to_port_en and to_bus_en are low, rd_wr_n is high and ready is high.
- R2: On a qualified access, port_cs is one-hot with bit k set, where k is the value of addr[3:2] (00 gives port 0, 11 gives port 3).
- R3: On a qualified access, reg_sel equals addr[1:0]. The encoding is 00 section A control, 01 section A data, 10 section B control, 11 section B data.
- R4: bus_en is high exactly when an access is qualified and strb_din or strb_wr is high.
- R5: A qualified access with sts_out high drives rd_wr_n low and to_port_en high.
- R6: A qualified access with sts_in high drives to_bus_en high. If sts_out is low, rd_wr_n stays high.
- R7: A qualified input access (sts_in high) pulls ready low. The low starts combinationally in its first cycle and lasts exactly WAIT_CYCLES clock cycles (default 125, i.e. 500 ns at 250 MHz). After that, ready stays high for as long as the same access is held.
- R8: A qualified access with sts_out high and sts_in low never pulls ready low.
- R9: If the input access ends before the wait expires, ready goes high at once. The next input access waits the full WAIT_CYCLES again.
- R10: While poc is high, port_rst is high and ready is high. poc clears the wait timer, so an input access still present after poc falls waits the full WAIT_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| poc | input | 1 | Power-on clear, active high, asynchronous |
| addr | input | 8 | I/O device address |
| sts_in | input | 1 | Input-instruction status |
| sts_out | input | 1 | Output-instruction status |
| strb_din | input | 1 | Data-in strobe |
| strb_wr | input | 1 | Write strobe |
| base_sel | input | 4 | Board base setting, compared with addr[7:4] |
| port_cs | output | 4 | One-hot port chip select |
| reg_sel | output | 2 | Register select within the port |
| rd_wr_n | output | 1 | High for read, low for write |
| bus_en | output | 1 | Per-cycle enable strobe to the ports |
| to_port_en | output | 1 | Enables the bus-to-port data buffers |
| to_bus_en | output | 1 | Enables the port-to-bus drivers |
| ready | output | 1 | Bus ready, low while waiting |
| port_rst | output | 1 | Reset line to all ports |

## Verification
The decode outputs (chip select, register select, read/write, enable strobe and buffer enables) and port_rst follow the inputs in the same cycle. Ready drops in the same cycle as a qualified input access begins and returns high in the cycle after the WAIT_CYCLES-th low cycle.

The bench drives inputs on the falling edge and pushes the expected outputs for that cycle into a queue. A monitor compares them 1 ns later, before the next rising edge, so each comparison sees the registered wait state after exactly the number of rising edges the model counted. The bench's wait model counts consecutive qualified input cycles on its own. It restarts that count on abort or power-on clear, which fixes the exact cycle in which ready is due to rise.

// File: rtl/io_dec_pkg.sv
`timescale 1ns/1ps
package io_dec_pkg;

  typedef enum logic [1:0] {
    WT_IDLE  = 2'd0,
    WT_COUNT = 2'd1,
    WT_DONE  = 2'd2
  } wait_state_e;

  // Board window match: upper address field against the base setting.
  function automatic logic window_hit(input logic [7:0] hi_field,
                                      input logic [7:0] base_val);
    return hi_field == base_val;
  endfunction

  // True in the last counting cycle of the wait timer.
  function automatic logic wait_last(input int unsigned count_val,
                                     input int unsigned total);
    return count_val + 2 >= total;
  endfunction

endpackage

// File: rtl/dec_addr_match.sv
`timescale 1ns/1ps
module dec_addr_match #(
  parameter int ADDR_W    = 8,
  parameter int PORT_BITS = 2,
  parameter int REG_BITS  = 2
) (
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [ADDR_W-PORT_BITS-REG_BITS-1:0] base_sel,
  input  logic                               sts_in,
  input  logic                               sts_out,
  output logic                               board_hit,
  output logic                               access,
  output logic [(1<<PORT_BITS)-1:0]          port_cs,
  output logic [REG_BITS-1:0]                reg_sel
);
  import io_dec_pkg::*;

  localparam int BASE_W    = ADDR_W - PORT_BITS - REG_BITS;
  localparam int NUM_PORTS = 1 << PORT_BITS;

  logic [BASE_W-1:0]    base_field;
  logic [PORT_BITS-1:0] port_field;

  assign base_field = addr[ADDR_W-1 -: BASE_W];
  assign port_field = addr[REG_BITS +: PORT_BITS];

  assign board_hit = window_hit(8'(base_field), 8'(base_sel));
  assign access    = board_hit && (sts_in || sts_out);
  assign reg_sel   = access ? addr[REG_BITS-1:0] : '0;

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_cs
    assign port_cs[k] = access && (port_field == PORT_BITS'(k));
  end

endmodule

// File: rtl/dec_strobe_gen.sv
`timescale 1ns/1ps
module dec_strobe_gen (
  input  logic access,
  input  logic sts_in,
  input  logic sts_out,
  input  logic strb_din,
  input  logic strb_wr,
  output logic in_acc,
  output logic bus_en,
  output logic rd_wr_n,
  output logic to_port_en,
  output logic to_bus_en
);
  logic out_acc;

  assign in_acc     = access && sts_in;
  assign out_acc    = access && sts_out;
  assign bus_en     = access && (strb_din || strb_wr);
  assign rd_wr_n    = !out_acc;
  assign to_port_en = out_acc;
  assign to_bus_en  = in_acc;

endmodule

// File: rtl/dec_wait_timer.sv
`timescale 1ns/1ps
module dec_wait_timer #(
  parameter int WAIT_CYCLES = 125
) (
  input  logic clk,
  input  logic poc,
  input  logic in_acc,
  output logic ready,
  output logic wait_start,
  output logic wait_busy
);
  import io_dec_pkg::*;

  localparam int CNT_W = (WAIT_CYCLES > 2) ? $clog2(WAIT_CYCLES) : 1;

  wait_state_e      state, state_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;

  assign wait_start = (state == WT_IDLE) && in_acc && !poc;
  assign wait_busy  = in_acc && (state != WT_DONE) && !poc;
  assign ready      = !wait_busy;

  always_comb begin
    state_nx = state;
    cnt_nx   = cnt;
    unique case (state)
      WT_IDLE: begin
        cnt_nx = '0;
        if (in_acc) state_nx = (WAIT_CYCLES <= 1) ? WT_DONE : WT_COUNT;
      end
      WT_COUNT: begin
        if (!in_acc) state_nx = WT_IDLE;
        else if (wait_last(int'(cnt), WAIT_CYCLES)) state_nx = WT_DONE;
        else cnt_nx = cnt + 1'b1;
      end
      WT_DONE: if (!in_acc) state_nx = WT_IDLE;
      default: state_nx = WT_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge poc) begin
    if (poc) begin
      state <= WT_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      cnt   <= cnt_nx;
    end
  end

endmodule

// File: rtl/io_port_decoder.sv
`timescale 1ns/1ps
module io_port_decoder #(
  parameter int ADDR_W      = 8,
  parameter int PORT_BITS   = 2,
  parameter int REG_BITS    = 2,
  parameter int WAIT_CYCLES = 125
) (
  input  logic                                 clk,
  input  logic                                 poc,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic                                 sts_in,
  input  logic                                 sts_out,
  input  logic                                 strb_din,
  input  logic                                 strb_wr,
  input  logic [ADDR_W-PORT_BITS-REG_BITS-1:0] base_sel,
  output logic [(1<<PORT_BITS)-1:0]            port_cs,
  output logic [REG_BITS-1:0]                  reg_sel,
  output logic                                 rd_wr_n,
  output logic                                 bus_en,
  output logic                                 to_port_en,
  output logic                                 to_bus_en,
  output logic                                 ready,
  output logic                                 port_rst
);
  logic board_hit;
  logic access;
  logic in_acc;
  logic wait_start;
  logic wait_busy;

  dec_addr_match #(.ADDR_W(ADDR_W), .PORT_BITS(PORT_BITS), .REG_BITS(REG_BITS)) u_match (
    .addr(addr), .base_sel(base_sel), .sts_in(sts_in), .sts_out(sts_out),
    .board_hit(board_hit), .access(access), .port_cs(port_cs), .reg_sel(reg_sel)
  );

  dec_strobe_gen u_strobe (
    .access(access), .sts_in(sts_in), .sts_out(sts_out),
    .strb_din(strb_din), .strb_wr(strb_wr), .in_acc(in_acc),
    .bus_en(bus_en), .rd_wr_n(rd_wr_n),
    .to_port_en(to_port_en), .to_bus_en(to_bus_en)
  );

  dec_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
    .clk(clk), .poc(poc), .in_acc(in_acc),
    .ready(ready), .wait_start(wait_start), .wait_busy(wait_busy)
  );

  assign port_rst = poc;

endmodule

// File: rtl/io_port_decoder_chk.sv
`timescale 1ns/1ps
module io_port_decoder_chk #(
  parameter int WAIT_CYCLES = 125
) (
  input logic       clk,
  input logic       poc,
  input logic [7:0] addr,
  input logic [3:0] base_sel,
  input logic       sts_in,
  input logic       sts_out,
  input logic [3:0] port_cs,
  input logic       rd_wr_n,
  input logic       ready,
  input logic       port_rst,
  input logic       in_acc,
  input logic       wait_start
);
  logic [15:0] low_run;

  always_ff @(posedge clk or posedge poc) begin
    if (poc) low_run <= '0;
    else if (!ready) low_run <= low_run + 16'd1;
    else low_run <= '0;
  end

  a_r2_onehot_cs: assert property (@(posedge clk) disable iff (poc)
    $onehot0(port_cs));

  a_r1_miss_quiet: assert property (@(posedge clk) disable iff (poc)
    (addr[7:4] != base_sel) |-> (port_cs == 4'd0 && ready));

  a_r5_write_dir: assert property (@(posedge clk) disable iff (poc)
    (addr[7:4] == base_sel && sts_out) |-> !rd_wr_n);

  a_r8_no_out_wait: assert property (@(posedge clk) disable iff (poc)
    (sts_out && !sts_in) |-> ready);

  a_r9_idle_ready: assert property (@(posedge clk) disable iff (poc)
    !in_acc |-> ready);

  a_r7_start_low: assert property (@(posedge clk) disable iff (poc)
    wait_start |-> !ready);

  a_r7_max_low: assert property (@(posedge clk) disable iff (poc)
    !ready |-> (low_run < 16'(WAIT_CYCLES)));

  a_r7_release: assert property (@(posedge clk) disable iff (poc)
    (!ready && low_run == 16'(WAIT_CYCLES - 1)) |=> ready);

  always_comb begin
    if (poc) begin
      a_r10_poc_out: assert (port_rst && ready);
    end
  end

endmodule

bind io_port_decoder io_port_decoder_chk #(.WAIT_CYCLES(WAIT_CYCLES)) u_chk (
  .clk(clk), .poc(poc), .addr(addr), .base_sel(base_sel),
  .sts_in(sts_in), .sts_out(sts_out), .port_cs(port_cs), .rd_wr_n(rd_wr_n),
  .ready(ready), .port_rst(port_rst), .in_acc(in_acc), .wait_start(wait_start)
);

// File: tb/io_port_decoder_test.sv
`timescale 1ns/1ps
module io_port_decoder_test;
  localparam int W = 125;

  logic clk = 1'b0;
  logic poc = 1'b1;
  logic [7:0] addr = '0;
  logic sts_in = 1'b0, sts_out = 1'b0, strb_din = 1'b0, strb_wr = 1'b0;
  logic [3:0] base_sel = '0;
  logic [3:0] port_cs;
  logic [1:0] reg_sel;
  logic rd_wr_n, bus_en, to_port_en, to_bus_en, ready, port_rst;

  always #2 clk = ~clk;

  io_port_decoder #(.WAIT_CYCLES(W)) uut (
    .clk(clk), .poc(poc), .addr(addr), .sts_in(sts_in), .sts_out(sts_out),
    .strb_din(strb_din), .strb_wr(strb_wr), .base_sel(base_sel),
    .port_cs(port_cs), .reg_sel(reg_sel), .rd_wr_n(rd_wr_n), .bus_en(bus_en),
    .to_port_en(to_port_en), .to_bus_en(to_bus_en), .ready(ready), .port_rst(port_rst)
  );

  typedef struct {
    logic [11:0] vec;
    string       tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  int run = 0;
  bit finished = 0;

  // Vector layout: cs[11:8] rs[7:6] rw en tp tb rdy rst
  function automatic logic [11:0] pack_obs();
    return {port_cs, reg_sel, rd_wr_n, bus_en, to_port_en, to_bus_en, ready, port_rst};
  endfunction

  task automatic step(input logic [7:0] a, input bit si, input bit so,
                      input bit di, input bit wr, input logic [3:0] b,
                      input bit p, input string tag);
    bit hit, acc, inq;
    logic [3:0] cs;
    logic [1:0] rs;
    bit rdy;
    exp_t e;
    @(negedge clk);
    addr = a; sts_in = si; sts_out = so; strb_din = di; strb_wr = wr;
    base_sel = b; poc = p;
    hit = (a / 16) == b;
    acc = hit && (si || so);
    inq = acc && si;
    cs  = acc ? (4'b0001 << (a % 16) / 4) : 4'b0000;
    rs  = acc ? 2'(a % 4) : 2'b00;
    rdy = p || !(inq && run < W);
    e.vec = {cs, rs, !(acc && so), acc && (di || wr), acc && so, inq, rdy, p};
    e.tag = tag;
    q.push_back(e);
    run = (p || !inq) ? 0 : run + 1;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        logic [11:0] got;
        e = q.pop_front();
        got = pack_obs();
        total++;
        if (got !== e.vec) begin
          bad++;
          $display("FAIL %s: actual=%b expected=%b", e.tag, got, e.vec);
        end
      end
    end
  end

  initial begin : main
    // R10: reset state while power-on clear is held, with an input access present
    step(8'h20, 1, 0, 1, 0, 4'h2, 1, "R10 poc reset state");
    step(8'h20, 1, 0, 1, 0, 4'h2, 1, "R10 poc holds ready");
    step(8'h00, 0, 0, 0, 0, 4'h2, 0, "R1 idle after poc");
    // R1: base mismatch and missing status
    step(8'h35, 0, 1, 0, 1, 4'h2, 0, "R1 base mismatch");
    step(8'h25, 0, 0, 1, 1, 4'h2, 0, "R1 no status");
    // R2/R3/R4/R5/R8: writes over all ports and registers, no wait
    for (int k = 0; k < 16; k++)
      step(8'h20 + 8'(k), 0, 1, 0, (k % 2) == 0, 4'h2, 0, "R2 R3 R4 R5 R8 write sweep");
    step(8'hF7, 0, 1, 0, 0, 4'hF, 0, "R4 no strobe no enable");
    // R6/R7: held input access waits W cycles then stays ready
    for (int k = 0; k < W + 4; k++)
      step(8'h2E, 1, 0, 1, 0, 4'h2, 0, "R6 R7 input wait");
    step(8'h00, 0, 0, 0, 0, 4'h2, 0, "R7 idle");
    // R9: abort partway, then full wait again
    for (int k = 0; k < 10; k++)
      step(8'h29, 1, 0, 1, 0, 4'h2, 0, "R9 partial wait");
    step(8'h29, 0, 0, 0, 0, 4'h2, 0, "R9 abort releases");
    for (int k = 0; k < W + 2; k++)
      step(8'h2B, 1, 0, 0, 0, 4'h2, 0, "R9 full restart");
    step(8'h00, 0, 0, 0, 0, 4'h2, 0, "R9 idle");
    // R10: poc in the middle of a wait, then the held access waits afresh
    for (int k = 0; k < 20; k++)
      step(8'h24, 1, 0, 1, 0, 4'h2, 0, "R10 pre poc wait");
    step(8'h24, 1, 0, 1, 0, 4'h2, 1, "R10 poc mid wait");
    for (int k = 0; k < W + 2; k++)
      step(8'h24, 1, 0, 1, 0, 4'h2, 0, "R10 fresh wait after poc");
    step(8'h00, 0, 0, 0, 0, 4'h2, 0, "R1 final idle");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 4);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule